// File: doc/BRIEF.md
# Shadow-Stack Control-Flow Checker

This block watches the stream of retired instructions and polices control flow in hardware. Every call stores its return address on a private stack held inside the block. This stack runs in parallel with the program's ordinary stack and has no write path from data stores. Every return removes the newest private entry and compares it with the return address that the program read from its ordinary stack. A difference means the return address was overwritten, which is the first step of an attack that chains fragments of existing code. The block flags it.

The block also follows indirect transfers. After an indirect jump or an indirect call, the next retired instruction must be a landing-pad marker. The block also catches a private stack that is pushed past capacity or popped while empty.

Once any violation is seen, the block freezes. It latches the cause, ignores all further events and holds its state until a synchronous clear restarts it from empty. A retire unit drives one event per cycle. An exception path outside this block reads the violation flag and the cause code.

Top module: `cfi_guard`

## Requirements
- R1: After reset, `viol` is 0, `viol_cause` is 00, `depth` is 0, `empty` is 1 and `full` is 0.
- R2: An accepted event with `ev_kind` 1 (direct call) or 2 (indirect call), when the stack is not full, stores `ev_addr` as the newest entry. `depth` rises by one in the cycle after the event.
- R3: An accepted event with `ev_kind` 3 (return) whose `ev_addr` equals the newest stored entry removes that entry. `depth` falls by one and no violation is raised. Entries come back in last-in, first-out order.
- R4: A return whose `ev_addr` differs from the newest stored entry sets `viol` with `viol_cause` 01 in the cycle after the event.
- R5: After an accepted indirect call (`ev_kind` 2) or indirect jump (`ev_kind` 4), the next accepted event must be a marker (`ev_kind` 5). Any other kind sets `viol` with `viol_cause` 10 and leaves the stack unchanged. A marker satisfies and removes the expectation.
- R6: A direct jump (`ev_kind` 6), a plain instruction (`ev_kind` 0 or 7), or a marker with no expectation pending changes neither `depth` nor `viol`. None of these removes an expectation left by an indirect transfer.
- R7: A call at `depth` equal to DEPTH (32) sets `viol` with `viol_cause` 11, and `depth` stays at 32.
- R8: A return at `depth` 0 sets `viol` with `viol_cause` 11.
- R9: While `viol` is 1, every event is ignored. `depth` and `viol_cause` keep their values until `clr` is asserted.
- R10: `clr` is synchronous. In the cycle after it, `viol` is 0, `viol_cause` is 00, `depth` is 0 and no landing pad is expected. An event presented together with `clr` is ignored.
- R11: Only call events write the stack. Events of other kinds carrying arbitrary `ev_addr` values leave stored entries intact, so a later matching return still passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous restart: clears the violation, empties the stack, drops any pad expectation |
| ev_valid | input | 1 | A retire event is present this cycle |
| ev_kind | input | 3 | 0 plain, 1 direct call, 2 indirect call, 3 return, 4 indirect jump, 5 marker, 6 direct jump, 7 plain |
| ev_addr | input | 32 | Return address to store on a call; return address read from the ordinary stack on a return |
| viol | output | 1 | Violation latched |
| viol_cause | output | 2 | 01 return mismatch, 10 missing landing pad, 11 stack overflow or underflow |
| depth | output | 6 | Number of stored return addresses |
| empty | output | 1 | Stack holds no entry |
| full | output | 1 | Stack holds DEPTH entries |

## Verification
A corrupted stack entry or pointer does not show at once. It stays hidden until the matching return, which may be many events later. At that return it shows as a false mismatch (cause 01) or a false underflow. For this reason the bench nests calls, inserts non-call events carrying foreign addresses, and then unwinds every level. A stuck or lost landing-pad expectation shows in the cycle after the next event, as a cause 10 where none belongs or a missing one. Each event is therefore followed by one exact comparison of flag, cause and depth one cycle later.

// File: rtl/cfi_pkg.sv
// Shared encodings for the shadow-stack control-flow checker.
// Assumes one retire event per cycle at most.
package cfi_pkg;

    // Kind of retired instruction presented on ev_kind
    typedef enum logic [2:0] {
        EV_PLAIN  = 3'd0,
        EV_CALL   = 3'd1,
        EV_ICALL  = 3'd2,
        EV_RET    = 3'd3,
        EV_IJMP   = 3'd4,
        EV_MARKER = 3'd5,
        EV_JMP    = 3'd6,
        EV_PLAIN7 = 3'd7
    } ev_kind_e;

    // Reason reported with a violation
    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_RET   = 2'b01,
        CAUSE_PAD   = 2'b10,
        CAUSE_STACK = 2'b11
    } cause_e;

endpackage

// File: rtl/cfi_shadow_stack.sv
// Private return-address stack.
// Written only through the push port and read only at the newest entry.
// Assumes push is never asserted when full and pop never when empty.
// The caller guarantees both.
module cfi_shadow_stack #(
    parameter int DEPTH = 32,
    parameter int W     = 32,
    parameter int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     push_data,
    output logic [W-1:0]     top_data,
    output logic [PTR_W-1:0] level,
    output logic             empty,
    output logic             full
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] ptr_m1;

    assign ptr_m1   = ptr - PTR_W'(1);
    assign top_data = mem[ptr_m1[IDX_W-1:0]];
    assign level    = ptr;
    assign empty    = (ptr == '0);
    assign full     = (ptr == PTR_W'(DEPTH));

    // Pointer: count of stored entries
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ptr <= '0;
        end else if (push) begin
            ptr <= ptr + PTR_W'(1);
        end else if (pop) begin
            ptr <= ptr_m1;
        end
    end

    // Storage: written only by a call push
    always_ff @(posedge clk) begin
        if (push) begin
            mem[ptr[IDX_W-1:0]] <= push_data;
        end
    end
endmodule

// File: rtl/cfi_pad_tracker.sv
// Holds the expectation that the next event is a landing-pad marker.
// Set by an accepted indirect transfer, cleared only by a marker,
// by flush or by reset.
module cfi_pad_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic set_pad,
    input  logic clr_pad,
    output logic pad_pending
);
    // Pending flag update; set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            pad_pending <= 1'b0;
        end else if (set_pad) begin
            pad_pending <= 1'b1;
        end else if (clr_pad) begin
            pad_pending <= 1'b0;
        end
    end
endmodule

// File: rtl/cfi_verdict.sv
// Combinational decision for one accepted event.
// Picks the stack action, the pad action and any fault.
// A missing pad is checked first. A faulting event modifies nothing.
module cfi_verdict
    import cfi_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         accept,
    input  ev_kind_e     kind,
    input  logic [W-1:0] addr,
    input  logic         pad_pending,
    input  logic [W-1:0] top_data,
    input  logic         empty,
    input  logic         full,
    output logic         push,
    output logic         pop,
    output logic         set_pad,
    output logic         clr_pad,
    output logic         fault,
    output cause_e       fault_cause
);
    // Event classification and fault detection
    always_comb begin
        push        = 1'b0;
        pop         = 1'b0;
        set_pad     = 1'b0;
        clr_pad     = 1'b0;
        fault       = 1'b0;
        fault_cause = CAUSE_NONE;
        if (accept) begin
            if (pad_pending && kind != EV_MARKER) begin
                fault       = 1'b1;
                fault_cause = CAUSE_PAD;
            end else begin
                unique case (kind)
                    EV_CALL, EV_ICALL: begin
                        if (full) begin
                            fault       = 1'b1;
                            fault_cause = CAUSE_STACK;
                        end else begin
                            push    = 1'b1;
                            set_pad = (kind == EV_ICALL);
                        end
                    end
                    EV_RET: begin
                        if (empty) begin
                            fault       = 1'b1;
                            fault_cause = CAUSE_STACK;
                        end else if (top_data != addr) begin
                            fault       = 1'b1;
                            fault_cause = CAUSE_RET;
                        end else begin
                            pop = 1'b1;
                        end
                    end
                    EV_IJMP:   set_pad = 1'b1;
                    EV_MARKER: clr_pad = 1'b1;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfi_guard.sv
// Top of the shadow-stack control-flow checker.
// Accepts one retire event per cycle unless a violation is latched.
// The latch clears only with clr. Outputs are registered: an event
// presented before a clock edge shows its effect right after that edge.
module cfi_guard
    import cfi_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int W     = 32,
    parameter int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ev_valid,
    input  logic [2:0]       ev_kind,
    input  logic [W-1:0]     ev_addr,
    output logic             viol,
    output logic [1:0]       viol_cause,
    output logic [PTR_W-1:0] depth,
    output logic             empty,
    output logic             full
);
    logic         accept;
    logic         push, pop, set_pad, clr_pad, fault;
    cause_e       fault_cause;
    logic         pad_pending;
    logic [W-1:0] top_data;
    logic         viol_q;
    cause_e       cause_q;

    assign accept     = ev_valid && !viol_q && !clr;
    assign viol       = viol_q;
    assign viol_cause = cause_q;

    cfi_shadow_stack #(.DEPTH(DEPTH), .W(W), .PTR_W(PTR_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (clr),
        .push      (push),
        .pop       (pop),
        .push_data (ev_addr),
        .top_data  (top_data),
        .level     (depth),
        .empty     (empty),
        .full      (full)
    );

    cfi_pad_tracker u_pad (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (clr),
        .set_pad     (set_pad),
        .clr_pad     (clr_pad),
        .pad_pending (pad_pending)
    );

    cfi_verdict #(.W(W)) u_verdict (
        .accept      (accept),
        .kind        (ev_kind_e'(ev_kind)),
        .addr        (ev_addr),
        .pad_pending (pad_pending),
        .top_data    (top_data),
        .empty       (empty),
        .full        (full),
        .push        (push),
        .pop         (pop),
        .set_pad     (set_pad),
        .clr_pad     (clr_pad),
        .fault       (fault),
        .fault_cause (fault_cause)
    );

    // Violation latch with cause; cleared only by reset or clr
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            viol_q  <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else if (fault) begin
            viol_q  <= 1'b1;
            cause_q <= fault_cause;
        end
    end
endmodule

// File: rtl/cfi_guard_chk.sv
// Property checker for cfi_guard, attached with bind.
// Observes the ports and the internal pad expectation.
module cfi_guard_chk #(
    parameter int DEPTH = 32,
    parameter int PTR_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             ev_valid,
    input logic [2:0]       ev_kind,
    input logic             viol,
    input logic [1:0]       viol_cause,
    input logic [PTR_W-1:0] depth,
    input logic             pad_pending
);
    logic acc;
    assign acc = ev_valid && !viol && !clr;

    // R7: depth never exceeds capacity
    p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= PTR_W'(DEPTH));

    // R2: an accepted call with room and no pad pending adds one entry
    p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !pad_pending && (ev_kind == 3'd1 || ev_kind == 3'd2)
         && depth < PTR_W'(DEPTH))
        |=> (depth == $past(depth) + PTR_W'(1)) && !viol);

    // R8: a return on an empty stack is an underflow
    p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !pad_pending && ev_kind == 3'd3 && depth == '0)
        |=> viol && viol_cause == 2'b11);

    // R5: a non-marker after an indirect transfer is a pad violation
    p_pad_missing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pad_pending && ev_kind != 3'd5)
        |=> viol && viol_cause == 2'b10 && $stable(depth));

    // R9: a latched violation freezes state until clr
    p_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && !clr) |=> viol && $stable(viol_cause) && $stable(depth));

    // R10: clr restarts from empty with no violation
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !viol && viol_cause == 2'b00 && depth == '0 && !pad_pending);

    // R4: a violation always carries a nonzero cause
    p_cause_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> viol_cause != 2'b00);
endmodule

bind cfi_guard cfi_guard_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_cfi_guard_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .ev_valid    (ev_valid),
    .ev_kind     (ev_kind),
    .viol        (viol),
    .viol_cause  (viol_cause),
    .depth       (depth),
    .pad_pending (pad_pending)
);

// File: tb/test_cfi_guard.sv
// Scoreboard bench for cfi_guard.
// The driver computes the expected outputs from a model of the
// requirements and queues them. The monitor compares them after the
// clock edge that applies each event.
module test_cfi_guard;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        ev_valid = 1'b0;
    logic [2:0]  ev_kind = 3'd0;
    logic [31:0] ev_addr = '0;
    logic        viol;
    logic [1:0]  viol_cause;
    logic [5:0]  depth;
    logic        empty, full;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic       v;
        logic [1:0] c;
        logic [5:0] d;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    // Reference state
    logic [31:0] m_stk[$];
    logic        m_viol = 1'b0;
    logic [1:0]  m_cause = 2'b00;
    logic        m_pend = 1'b0;

    always #4 clk = ~clk;

    cfi_guard #(.DEPTH(DEPTH), .W(32)) i_cfi_guard (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ev_valid(ev_valid),
        .ev_kind(ev_kind), .ev_addr(ev_addr), .viol(viol),
        .viol_cause(viol_cause), .depth(depth), .empty(empty), .full(full)
    );

    task automatic compare(input string tag, input exp_t e);
        logic ee, ef;
        ee = (e.d == 0);
        ef = (e.d == 6'(DEPTH));
        checks++;
        if (viol !== e.v || viol_cause !== e.c || depth !== e.d
            || empty !== ee || full !== ef) begin
            errors++;
            $display("FAIL %s: got viol=%0b cause=%0d depth=%0d empty=%0b full=%0b, expected viol=%0b cause=%0d depth=%0d empty=%0b full=%0b",
                     tag, viol, viol_cause, depth, empty, full, e.v, e.c, e.d, ee, ef);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue its expected result
    task automatic step(input logic v, input logic [2:0] k,
                        input logic [31:0] a, input logic c, input string tag);
        exp_t e;
        @(negedge clk);
        ev_valid = v; ev_kind = k; ev_addr = a; clr = c;
        if (c) begin
            m_stk.delete(); m_viol = 1'b0; m_cause = 2'b00; m_pend = 1'b0;
        end else if (v && !m_viol) begin
            if (m_pend && k != 3'd5) begin
                m_viol = 1'b1; m_cause = 2'b10;
            end else begin
                case (k)
                    3'd1, 3'd2: begin
                        if (m_stk.size() == DEPTH) begin
                            m_viol = 1'b1; m_cause = 2'b11;
                        end else begin
                            m_stk.push_back(a);
                            if (k == 3'd2) m_pend = 1'b1;
                        end
                    end
                    3'd3: begin
                        if (m_stk.size() == 0) begin
                            m_viol = 1'b1; m_cause = 2'b11;
                        end else if (m_stk[m_stk.size()-1] != a) begin
                            m_viol = 1'b1; m_cause = 2'b01;
                        end else begin
                            void'(m_stk.pop_back());
                        end
                    end
                    3'd4: m_pend = 1'b1;
                    3'd5: m_pend = 1'b0;
                    default: ;
                endcase
            end
        end
        e.v = m_viol; e.c = m_cause; e.d = 6'(m_stk.size());
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare queued expectation after each applying edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                compare(tag_q.pop_front(), exp_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        r = '0;
        compare("R1 reset state", r);

        // Nested calls and in-order unwinding
        step(1, 3'd1, 32'h0000_A000, 0, "R2 call A");
        step(1, 3'd1, 32'h0000_B000, 0, "R2 call B");
        step(1, 3'd1, 32'h0000_C000, 0, "R2 call C");
        step(1, 3'd3, 32'h0000_C000, 0, "R3 ret C");
        step(1, 3'd3, 32'h0000_B000, 0, "R3 ret B");
        step(1, 3'd3, 32'h0000_BAD0, 0, "R4 ret mismatch");
        step(1, 3'd1, 32'h0000_1234, 0, "R9 call ignored when locked");
        step(1, 3'd3, 32'h0000_A000, 0, "R9 ret ignored when locked");
        step(0, 3'd0, 32'h0, 0, "R9 idle keeps lock");
        step(1, 3'd1, 32'h0000_7777, 1, "R10 clear wins over call");
        step(0, 3'd0, 32'h0, 0, "R10 idle after clear");

        // Landing-pad tracking
        step(1, 3'd4, 32'h0000_0040, 0, "R5 indirect jump");
        step(1, 3'd5, 32'h0, 0, "R5 marker satisfies");
        step(1, 3'd0, 32'h0, 0, "R6 plain after satisfied pad");
        step(1, 3'd2, 32'h0000_D000, 0, "R2 indirect call pushes");
        step(1, 3'd5, 32'h0, 0, "R5 marker after indirect call");
        step(1, 3'd3, 32'h0000_D000, 0, "R3 ret from indirect call");
        step(1, 3'd4, 32'h0000_0080, 0, "R5 indirect jump again");
        step(1, 3'd6, 32'h0, 0, "R6 direct jump does not clear pad");
        step(1, 3'd0, 32'h0, 1, "R10 clear after pad fault");
        step(1, 3'd5, 32'h0, 0, "R6 marker with nothing pending");
        step(1, 3'd0, 32'h0, 0, "R6 plain instruction");
        step(1, 3'd7, 32'h0, 0, "R6 plain kind 7");
        step(1, 3'd6, 32'h0, 0, "R6 direct jump idle");
        step(1, 3'd2, 32'h0000_E000, 0, "R2 indirect call");
        step(1, 3'd3, 32'h0000_E000, 0, "R5 ret instead of marker");
        step(0, 3'd0, 32'h0, 1, "R10 clear");

        // Capacity limits
        for (int i = 0; i < DEPTH; i++) begin
            step(1, 3'd1, 32'h0001_0000 + 32'(i * 4), 0, "R2 fill stack");
        end
        step(1, 3'd1, 32'h0002_0000, 0, "R7 overflow");
        step(0, 3'd0, 32'h0, 1, "R10 clear after overflow");
        step(1, 3'd3, 32'h0000_0000, 0, "R8 underflow");
        step(0, 3'd0, 32'h0, 1, "R10 clear after underflow");

        // Only calls write the stack
        step(1, 3'd1, 32'hCAFE_0000, 0, "R11 call stores");
        step(1, 3'd0, 32'hDEAD_0001, 0, "R11 plain with address");
        step(1, 3'd6, 32'hDEAD_0002, 0, "R11 direct jump with address");
        step(1, 3'd4, 32'hDEAD_0003, 0, "R11 indirect jump with address");
        step(1, 3'd5, 32'hDEAD_0004, 0, "R11 marker with address");
        step(1, 3'd3, 32'hCAFE_0000, 0, "R11 ret still matches");
        step(0, 3'd0, 32'h0, 0, "R1 idle end");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule